// File: doc/BRIEF.md
# Two-Channel Timer with Buffered Pulse-Width Output

This block is a timer built around a free-running up-counter. The counter wraps at a programmable limit, and software can halt it with a stop bit. Two channels each hold one value register. A channel works either as an input capture, which latches the counter on a rising edge of its capture pin, or as an output compare. In compare mode a channel can drive a pulse-width output. That output goes high when the counter wraps and goes low when the counter equals the channel's compare value.

Setting the link bit in channel 0's control register pairs the two value registers into one buffered duty source for output 0. One register is active and the other is a shadow. Software writes the new pulse width into the shadow. The new width takes effect at the next wrap, and the two registers then trade roles, so the output never sees a partly written width.

A wrap sets an overflow flag, and each capture or compare sets that channel's flag. Each flag has an interrupt enable. A flag is cleared by reading its register while it shows 1, then writing the register with the flag bit 0. An external break input freezes the counter. During break, flag clearing is allowed only when the break-clear-enable input is high.

Top module: `dual_ch_pwm_timer`

## Requirements
- R1: After reset the status register (address 0) reads 0x0001, which is the stop bit (bit 0) set. The counter (address 1) reads 0, the limit (address 2) reads all ones, and all outputs are low.
- R2: While running, the counter counts up by one per clock. On the clock after it equals the limit, it returns to 0.
- R3: While status bit 0 (stop) is 1, the counter holds its value. Writing 0 to bit 0 restarts counting.
- R4: A wrap sets the overflow flag (status bit 7). `irq_ovf` is high only while the flag is 1 and the overflow interrupt enable (status bit 1) is 1.
- R5: A flag clears only when its register was read with the flag at 1 and is then written with the flag bit 0. A write of 0 without that prior read leaves the flag set.
- R6: While `brk` is high, the counter holds its value.
- R7: While `brk` is high and `brk_clr_en` is low, the read-then-write sequence leaves flags set. While `brk_clr_en` is high, it clears them, and they stay cleared after `brk` falls.
- R8: Channel control bits are: bit 0 interrupt enable, bit 1 compare mode (0 means capture), bit 2 pulse-width enable, bit 3 link (channel 0 only), bit 4 set-on-wrap, bit 5 full duty, and bit 7 flag. With bits 1, 2 and 4 set and limit M, output i is high for value+1 of every M+1 clocks.
- R9: A compare match sets the channel flag (control bit 7). `irq_ch[i]` is high only while that flag and the channel's enable bit 0 are both 1.
- R10: In capture mode, a rising edge on `cap_in[i]` copies the counter into the channel's value register (channel 0 at address 4, channel 1 at address 6) and sets the channel flag.
- R11: With set-on-wrap (bit 4) clear, the pulse-width output stays low, which is 0% duty.
- R12: With both full duty (bit 5) and set-on-wrap (bit 4) set, the pulse-width output stays high, which is 100% duty.
- R13: With the link bit set, output 0 uses channel 0's value first. A write to the inactive channel's value register becomes the active width at the next wrap, and the roles of the two registers then swap.
- R14: The link bit takes priority over channel 0's pulse-width enable bit. While linked, output 1 stays low whatever channel 1's control bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| brk | input | 1 | Break: freezes the counter |
| brk_clr_en | input | 1 | Allows flag clearing during break |
| cap_in | input | 2 | Capture pins, one per channel |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flag clearing) |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data (combinational) |
| pwm_out | output | 2 | Pulse-width outputs |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_ch | output | 2 | Channel interrupt requests |

## Verification
Output 0 is driven with a mid-range width, with set-on-wrap cleared, and with full duty. These cases measure the high count over two whole periods, which separates the normal case from the 0% and 100% paths. In linked mode the bench writes the shadow register twice, once on each side. The measured width must follow each write, and an unbuffered channel 0 would ignore the second register entirely. The flag tests pair a write with and without the arming read, and inside break with the clear enable low and high, which separates a simple write-to-clear design from the armed protocol and from the break protection.

// File: rtl/dual_ch_pwm_timer.sv
module dual_ch_pwm_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          brk,
  input  logic          brk_clr_en,
  input  logic [1:0]    cap_in,
  input  logic [2:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic [1:0]    pwm_out,
  output logic          irq_ovf,
  output logic [1:0]    irq_ch
);
  localparam logic [2:0] A_ST = 3'd0, A_CNT = 3'd1, A_LIM = 3'd2;

  logic [CW-1:0] cnt, lim;
  logic [CW-1:0] val [2];
  logic [5:0]    cctl [2];
  logic halt, ovf_ie, ovf_f, ovf_arm, sel, pend;
  logic [1:0] chf, charm, cap_q, outq, out_nx, hit, cap_ev, wr_ctl, wr_val, rd_ctl;

  wire run     = !halt && !brk;
  wire ovf     = run && (cnt == lim);
  wire link    = cctl[0][3];
  wire can_clr = !brk || brk_clr_en;
  wire wr_st   = bus_wr && bus_addr == A_ST;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      wr_ctl[i] = bus_wr && bus_addr == 3'(3 + 2 * i);
      rd_ctl[i] = bus_rd && bus_addr == 3'(3 + 2 * i);
      wr_val[i] = bus_wr && bus_addr == 3'(4 + 2 * i);
      hit[i]    = run && cnt == val[i] && (link ? (sel == (i == 1)) : cctl[i][1]);
      cap_ev[i] = cap_in[i] && !cap_q[i] && !cctl[i][1] && !link;
    end
    out_nx[0] = !(link || cctl[0][2]) ? 1'b0 :
                (cctl[0][5] && cctl[0][4]) ? 1'b1 :
                (ovf && cctl[0][4]) ? 1'b1 :
                (link ? |hit : hit[0]) ? 1'b0 : outq[0];
    out_nx[1] = !(!link && cctl[1][2]) ? 1'b0 :
                (cctl[1][5] && cctl[1][4]) ? 1'b1 :
                (ovf && cctl[1][4]) ? 1'b1 :
                hit[1] ? 1'b0 : outq[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; lim <= '1; halt <= 1'b1; ovf_ie <= 1'b0; ovf_f <= 1'b0; ovf_arm <= 1'b0;
      sel <= 1'b0; pend <= 1'b0; chf <= '0; charm <= '0; cap_q <= '0; outq <= '0;
      for (int i = 0; i < 2; i++) begin
        val[i]  <= '0;
        cctl[i] <= '0;
      end
    end else begin
      if (run) cnt <= ovf ? '0 : cnt + 1'b1;
      cap_q <= cap_in;
      outq  <= out_nx;
      if (bus_rd && bus_addr == A_ST && ovf_f) ovf_arm <= 1'b1;
      if (wr_st) begin
        halt <= bus_wdata[0]; ovf_ie <= bus_wdata[1]; ovf_arm <= 1'b0;
      end
      if (ovf) ovf_f <= 1'b1;
      else if (wr_st && !bus_wdata[7] && ovf_arm && can_clr) ovf_f <= 1'b0;
      if (bus_wr && bus_addr == A_LIM) lim <= bus_wdata;
      for (int i = 0; i < 2; i++) begin
        if (rd_ctl[i] && chf[i]) charm[i] <= 1'b1;
        if (wr_ctl[i]) begin
          cctl[i] <= bus_wdata[5:0]; charm[i] <= 1'b0;
        end
        if (hit[i] || cap_ev[i]) chf[i] <= 1'b1;
        else if (wr_ctl[i] && !bus_wdata[7] && charm[i] && can_clr) chf[i] <= 1'b0;
        if (cap_ev[i]) val[i] <= cnt;
        if (wr_val[i]) val[i] <= bus_wdata;
      end
      if (!link) begin
        sel <= 1'b0; pend <= 1'b0;
      end else begin
        if (ovf && pend) begin
          sel <= ~sel; pend <= 1'b0;
        end
        if (sel ? wr_val[0] : wr_val[1]) pend <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_ST:    begin bus_rdata[0] = halt; bus_rdata[1] = ovf_ie; bus_rdata[7] = ovf_f; end
      A_CNT:   bus_rdata = cnt;
      A_LIM:   bus_rdata = lim;
      3'd3:    begin bus_rdata[5:0] = cctl[0]; bus_rdata[7] = chf[0]; end
      3'd4:    bus_rdata = val[0];
      3'd5:    begin bus_rdata[5:0] = cctl[1]; bus_rdata[7] = chf[1]; end
      3'd6:    bus_rdata = val[1];
      default: bus_rdata = '0;
    endcase
  end

  assign pwm_out = outq;
  assign irq_ovf = ovf_f && ovf_ie;
  assign irq_ch  = chf & {cctl[1][0], cctl[0][0]};

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == lim) |=> cnt == '0);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt || brk) |=> $stable(cnt));
  p_ovf_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == lim) |=> ovf_f);
  p_brk_protect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && !brk_clr_en && ovf_f) |=> ovf_f);
  p_zero_duty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cctl[0][4] && !pwm_out[0]) |=> !pwm_out[0]);
  p_full_duty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((link || cctl[0][2]) && cctl[0][5] && cctl[0][4]) |=> pwm_out[0]);
  p_link_out1_r14: assert property (@(posedge clk) disable iff (!rst_n)
    link |=> !pwm_out[1]);
endmodule

// File: tb/tb_dual_ch_pwm_timer.sv
module tb_dual_ch_pwm_timer;
  logic clk = 0, rst_n = 0, brk = 0, brk_clr_en = 0;
  logic [1:0] cap_in = '0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [1:0] pwm_out, irq_ch;
  logic irq_ovf;
  int total = 0, bad = 0;

  dual_ch_pwm_timer #(.CW(16)) dut (.*);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1; #1; d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic high_count(input int n, output int h, output int h1);
    h = 0; h1 = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      h += pwm_out[0];
      h1 += pwm_out[1];
    end
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(0, d); chk(d == 16'h0001, "R1 status", d, 1);
    rd(1, d); chk(d == 0, "R1 counter", d, 0);
    rd(2, d); chk(d == 16'hFFFF, "R1 limit", d, 16'hFFFF);
    chk(pwm_out == 0 && irq_ovf == 0 && irq_ch == 0, "R1 outputs", {pwm_out, irq_ovf, irq_ch}, 0);
  endtask

  task automatic t_count;
    logic [15:0] d, p, q;
    int errs = 0, wraps = 0;
    wr(2, 4);
    wr(0, 0);
    peek(1, p);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); peek(1, d);
      if (d != ((p == 4) ? 16'd0 : p + 16'd1)) errs++;
      if (p == 4 && d == 0) wraps++;
      p = d;
    end
    chk(errs == 0 && wraps >= 2, "R2 count and wrap", errs, 0);
    wr(0, 1);
    peek(1, p); idle(6); peek(1, q);
    chk(p == q, "R3 stop holds counter", q, p);
    rd(0, d); chk(d[7] == 1, "R4 overflow flag set", d[7], 1);
    chk(irq_ovf == 0, "R4 irq gated by enable", irq_ovf, 0);
    wr(0, 16'h0083);
    chk(irq_ovf == 1, "R4 irq with enable", irq_ovf, 1);
    wr(0, 16'h0003);
    rd(0, d); chk(d[7] == 1, "R5 write without read keeps flag", d[7], 1);
    wr(0, 16'h0003);
    rd(0, d); chk(d[7] == 0, "R5 read then write clears", d[7], 0);
    chk(irq_ovf == 0, "R5 irq drops", irq_ovf, 0);
  endtask

  task automatic t_break;
    logic [15:0] d, p, q;
    wr(0, 0); idle(8);
    brk = 1;
    peek(1, p); idle(5); peek(1, q);
    chk(p == q, "R6 break holds counter", q, p);
    rd(0, d); wr(0, 0);
    rd(0, d); chk(d[7] == 1, "R7 break protects flag", d[7], 1);
    brk_clr_en = 1;
    wr(0, 1);
    brk = 0; brk_clr_en = 0;
    idle(10);
    rd(0, d); chk(d[7] == 0, "R7 clear in break persists", d[7], 0);
  endtask

  task automatic t_pwm;
    logic [15:0] d;
    int h, h1;
    wr(2, 9); wr(4, 3); wr(3, 16'h0017); wr(0, 0);
    idle(12); high_count(20, h, h1);
    chk(h == 8, "R8 duty value+1 per period", h, 8);
    chk(irq_ch[0] == 1, "R9 channel irq on compare", irq_ch[0], 1);
    wr(3, 16'h0096);
    chk(irq_ch[0] == 0, "R9 irq gated by enable", irq_ch[0], 0);
    rd(3, d); chk(d[7] == 1, "R9 channel flag set", d[7], 1);
    wr(3, 16'h0086);
    idle(12); high_count(20, h, h1);
    chk(h == 0, "R11 zero duty", h, 0);
    wr(3, 16'h00B6);
    idle(2); high_count(20, h, h1);
    chk(h == 20, "R12 full duty", h, 20);
  endtask

  task automatic t_capture;
    logic [15:0] c, d;
    wr(0, 1);
    peek(1, c);
    wr(5, 16'h0001);
    cap_in[1] = 1; idle(2); cap_in[1] = 0;
    rd(6, d); chk(d == c, "R10 capture latches counter", d, c);
    rd(5, d); chk(d[7] == 1, "R10 capture sets flag", d[7], 1);
    chk(irq_ch[1] == 1, "R10 capture irq", irq_ch[1], 1);
  endtask

  task automatic t_buffered;
    int h, h1;
    wr(5, 0); wr(4, 2); wr(6, 8);
    wr(3, 16'h001E);
    wr(5, 16'h0016);
    wr(0, 0);
    idle(12); high_count(20, h, h1);
    chk(h == 6, "R13 channel 0 drives first", h, 6);
    chk(h1 == 0, "R14 output 1 low while linked", h1, 0);
    wr(6, 6);
    idle(25); high_count(20, h, h1);
    chk(h == 14, "R14 link over plain mode: shadow write used", h, 14);
    wr(4, 1);
    idle(25); high_count(20, h, h1);
    chk(h == 4, "R13 roles swap after wrap", h, 4);
  endtask

  initial begin
    #(20000 * 4);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    t_reset;
    t_count;
    t_break;
    t_pwm;
    t_capture;
    t_buffered;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule